// File: doc/BRIEF.md
# Framebuffer Display Transfer Converter

This block copies a rectangular image from one memory buffer to another and repacks each pixel on the way, from four bytes per pixel (red, green, blue, alpha) to three bytes per pixel, with the alpha byte discarded. Software writes a small bank of configuration words through a simple indexed write port. These words give the input and output base addresses in 8-byte units, packed width/height words for both images, a flags word holding the two format codes, and a start word.

Writing the start word with bit 0 set launches the transfer. The engine walks the output image row by row. For each pixel it issues one 32-bit read on the source port and then three byte writes on the destination port, each held until granted. While a transfer runs, `busy` is high. A one-cycle `done` pulse follows the last accepted byte. If the format pair is anything other than the supported one, `fmt_err` is set and no destination bytes are written.

Top module: `fb_xfer_convert`

## Requirements
- R1: After reset `busy`, `done`, `fmt_err`, `rd_en` and `wr_req` are all low.
- R2: A transfer starts only on a configuration write to index 6 whose data has bit 0 set. A write to index 6 with bit 0 clear starts nothing.
- R3: A start write that arrives while `busy` is high is ignored. The running transfer completes with exactly its own byte count, and no second transfer follows.
- R4: Pixels are visited row-major. There are H rows, where H is output-size bits 31:16, and W/2 columns per row (integer division), where W is output-size bits 15:0. Each pixel produces three byte writes at offsets +0, +1 and +2, in that order.
- R5: The source word for column x, row y is read at byte address Bin + 4x + y·(2·Win). Bin is the input address (index 0) times 8, and Win is input-size bits 15:0 (index 3).
- R6: The destination byte k of column x, row y is written at Bout + 3x + y·floor(3·W/2) + k. Bout is the output address (index 1) times 8.
- R7: Destination byte k (k = 0, 1, 2) equals source word bits 8k+7:8k. Bits 31:24 (alpha) are never written.
- R8: The flags word (index 4) holds the input format in bits 10:8 and the output format in bits 14:12. Code 0 means four bytes per pixel and code 1 means three bytes per pixel. Any pair other than input 0 with output 1 sets `fmt_err` and produces no destination write. `fmt_err` stays set until the next accepted start.
- R9: `done` is a single-cycle pulse raised the cycle after the last byte is granted, with `busy` already low. When W/2 or H is zero, `done` follows with no writes.
- R10: While `wr_req` is high and `wr_gnt` is low, `wr_req`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R11: Byte addresses are the 32-bit address words shifted left by 3, truncated to the address width, so the top three bits of an address word are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration word index (0..6) |
| cfg_wdata | input | 32 | Configuration write data |
| rd_en | output | 1 | Source read request, data returned the next cycle |
| rd_addr | output | ADDR_W | Source byte address |
| rd_data | input | 32 | Source word, valid one cycle after `rd_en` |
| wr_req | output | 1 | Destination byte write request |
| wr_addr | output | ADDR_W | Destination byte address |
| wr_data | output | 8 | Destination byte |
| wr_gnt | input | 1 | Destination grant; a byte is accepted when `wr_req` and `wr_gnt` are both high |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| fmt_err | output | 1 | Unsupported format pair seen in the last transfer |

## Verification
The main path is swept over input widths 2 and 6, output widths 1, 2 and 5, and output heights 1 and 3. This mix separates the half-width column count from the full width, the odd-width rounding of the destination row stride, and the source row stride, which follows the input width and not the output width. Each sweep point runs twice: once with the grant always high and once with the grant high only every third cycle, which exposes any byte that advances or changes before it is accepted. Base addresses change per point, and the output address has bit 29 set, so a missing ×8 scaling or a wrong truncation shows up in the addresses. A source word whose four bytes all differ separates lane order from dropped alpha. Zero-size images, bad format pairs in either field, and a start write during a transfer check the control rules.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
  localparam int IDX_W        = 3;
  localparam int NUM_CFG      = 5;
  localparam int IDX_IN_ADDR  = 0;
  localparam int IDX_OUT_ADDR = 1;
  localparam int IDX_OUT_SIZE = 2;
  localparam int IDX_IN_SIZE  = 3;
  localparam int IDX_FLAGS    = 4;
  localparam int IDX_START    = 6;

  localparam int IN_FMT_LSB   = 8;
  localparam int OUT_FMT_LSB  = 12;
  localparam int FMT_W        = 3;

  localparam logic [2:0] FMT_FOUR_BYTE  = 3'd0;
  localparam logic [2:0] FMT_THREE_BYTE = 3'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ,
    ST_CAPT,
    ST_WRITE
  } fbx_state_e;
endpackage

// File: rtl/fbx_cfg_regs.sv
module fbx_cfg_regs
  import fbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      in_addr_w,
  output logic [31:0]      out_addr_w,
  output logic [31:0]      out_size_w,
  output logic [31:0]      in_size_w,
  output logic [31:0]      flags_w,
  output logic             start_req
);
  logic [31:0] word_q [NUM_CFG];
  logic [31:0] word_n [NUM_CFG];

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_word
    always_comb begin
      word_n[i] = word_q[i];
      if (cfg_we && (cfg_idx == IDX_W'(i))) word_n[i] = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[i] <= '0;
      else        word_q[i] <= word_n[i];
    end
  end

  assign in_addr_w  = word_q[IDX_IN_ADDR];
  assign out_addr_w = word_q[IDX_OUT_ADDR];
  assign out_size_w = word_q[IDX_OUT_SIZE];
  assign in_size_w  = word_q[IDX_IN_SIZE];
  assign flags_w    = word_q[IDX_FLAGS];
  assign start_req  = cfg_we && (cfg_idx == IDX_W'(IDX_START)) && cfg_wdata[0];
endmodule

// File: rtl/fbx_walker.sv
module fbx_walker #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] out_base,
  input  logic [DIM_W-1:0]  in_w,
  input  logic [DIM_W-1:0]  out_w,
  input  logic [DIM_W-1:0]  out_h,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              last,
  output logic              empty
);
  logic [DIM_W-1:0]  cols_q, cols_n, rows_q, rows_n, x_q, x_n, y_q, y_n;
  logic [ADDR_W-1:0] sstr_q, sstr_n, dstr_q, dstr_n;
  logic [ADDR_W-1:0] srow_q, srow_n, drow_q, drow_n, spix_q, spix_n, dpix_q, dpix_n;
  logic [DIM_W+1:0]  ow3;
  logic              row_end;

  assign ow3     = {2'b00, out_w} + {1'b0, out_w, 1'b0};
  assign row_end = (x_q == cols_q - DIM_W'(1));
  assign last    = row_end && (y_q == rows_q - DIM_W'(1));
  assign empty   = (cols_q == '0) || (rows_q == '0);

  always_comb begin
    cols_n = cols_q; rows_n = rows_q; x_n = x_q; y_n = y_q;
    sstr_n = sstr_q; dstr_n = dstr_q;
    srow_n = srow_q; drow_n = drow_q; spix_n = spix_q; dpix_n = dpix_q;
    if (start) begin
      cols_n = out_w >> 1;
      rows_n = out_h;
      x_n    = '0;
      y_n    = '0;
      sstr_n = ADDR_W'({in_w, 1'b0});
      dstr_n = ADDR_W'(ow3 >> 1);
      srow_n = in_base;
      spix_n = in_base;
      drow_n = out_base;
      dpix_n = out_base;
    end else if (step) begin
      if (row_end) begin
        x_n    = '0;
        y_n    = y_q + DIM_W'(1);
        srow_n = srow_q + sstr_q;
        spix_n = srow_q + sstr_q;
        drow_n = drow_q + dstr_q;
        dpix_n = drow_q + dstr_q;
      end else begin
        x_n    = x_q + DIM_W'(1);
        spix_n = spix_q + ADDR_W'(4);
        dpix_n = dpix_q + ADDR_W'(3);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cols_q <= '0; rows_q <= '0; x_q <= '0; y_q <= '0;
      sstr_q <= '0; dstr_q <= '0;
      srow_q <= '0; drow_q <= '0; spix_q <= '0; dpix_q <= '0;
    end else begin
      cols_q <= cols_n; rows_q <= rows_n; x_q <= x_n; y_q <= y_n;
      sstr_q <= sstr_n; dstr_q <= dstr_n;
      srow_q <= srow_n; drow_q <= drow_n; spix_q <= spix_n; dpix_q <= dpix_n;
    end
  end

  assign src_addr = spix_q;
  assign dst_addr = dpix_q;

  assert_col_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cols_q != '0) |-> (x_q < cols_q));
  assert_row_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rows_q != '0) |-> (y_q < rows_q));
  assert_col_stride_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && !row_end) |=> (spix_q == $past(spix_q) + ADDR_W'(4)));
endmodule

// File: rtl/fbx_pixconv.sv
module fbx_pixconv
  import fbx_pkg::*;
(
  input  logic [31:0] flags,
  input  logic [31:0] word,
  input  logic [1:0]  sel,
  output logic        fmt_ok,
  output logic [7:0]  byte_out
);
  logic [7:0] lane [4];

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane[k] = word[8*k +: 8];
  end

  assign fmt_ok   = (flags[IN_FMT_LSB +: FMT_W]  == FMT_FOUR_BYTE) &&
                    (flags[OUT_FMT_LSB +: FMT_W] == FMT_THREE_BYTE);
  assign byte_out = lane[sel];
endmodule

// File: rtl/fb_xfer_convert.sv
module fb_xfer_convert
  import fbx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [31:0]       cfg_wdata,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_gnt,
  output logic              busy,
  output logic              done,
  output logic              fmt_err
);
  localparam int BYTES_OUT = 3;

  logic [31:0] in_addr_w, out_addr_w, out_size_w, in_size_w, flags_w;
  logic        start_req, start, step, last, empty, fmt_ok;
  logic [34:0] in_scaled, out_scaled;
  logic [ADDR_W-1:0] src_addr, dst_addr;

  fbx_state_e  state_q, state_n;
  logic [31:0] pix_q, pix_n, flags_q, flags_n;
  logic [1:0]  bcnt_q, bcnt_n;
  logic        err_q, err_n, done_q, done_n;

  fbx_cfg_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_wdata,
    .in_addr_w, .out_addr_w, .out_size_w, .in_size_w, .flags_w, .start_req
  );

  assign in_scaled  = {in_addr_w, 3'b000};
  assign out_scaled = {out_addr_w, 3'b000};
  assign start      = (state_q == ST_IDLE) && start_req;

  fbx_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_walk (
    .clk, .rst_n, .start, .step,
    .in_base (in_scaled[ADDR_W-1:0]),
    .out_base(out_scaled[ADDR_W-1:0]),
    .in_w    (in_size_w[DIM_W-1:0]),
    .out_w   (out_size_w[DIM_W-1:0]),
    .out_h   (out_size_w[16 +: DIM_W]),
    .src_addr, .dst_addr, .last, .empty
  );

  fbx_pixconv u_conv (
    .flags(flags_q), .word(pix_q), .sel(bcnt_q), .fmt_ok, .byte_out(wr_data)
  );

  always_comb begin
    state_n = state_q;
    pix_n   = pix_q;
    flags_n = flags_q;
    bcnt_n  = bcnt_q;
    err_n   = err_q;
    done_n  = 1'b0;
    step    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          flags_n = flags_w;
          err_n   = 1'b0;
          state_n = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (empty) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end else begin
          state_n = ST_READ;
        end
      end
      ST_READ: begin
        if (fmt_ok) begin
          state_n = ST_CAPT;
        end else begin
          err_n = 1'b1;
          if (last) begin
            state_n = ST_IDLE;
            done_n  = 1'b1;
          end else begin
            step = 1'b1;
          end
        end
      end
      ST_CAPT: begin
        pix_n   = rd_data;
        bcnt_n  = '0;
        state_n = ST_WRITE;
      end
      ST_WRITE: begin
        if (wr_gnt) begin
          if (bcnt_q == 2'(BYTES_OUT - 1)) begin
            if (last) begin
              state_n = ST_IDLE;
              done_n  = 1'b1;
            end else begin
              step    = 1'b1;
              state_n = ST_READ;
            end
          end else begin
            bcnt_n = bcnt_q + 2'd1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pix_q   <= '0;
      flags_q <= '0;
      bcnt_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      pix_q   <= pix_n;
      flags_q <= flags_n;
      bcnt_q  <= bcnt_n;
      err_q   <= err_n;
      done_q  <= done_n;
    end
  end

  assign rd_en   = (state_q == ST_READ) && fmt_ok;
  assign rd_addr = src_addr;
  assign wr_req  = (state_q == ST_WRITE);
  assign wr_addr = dst_addr + ADDR_W'(bcnt_q);
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign fmt_err = err_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_req && !rd_en));
  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_we && (cfg_idx == 3'd6) && cfg_wdata[0]));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_no_write_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !fmt_err);
  assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_gnt) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
endmodule

// File: tb/test_fb_xfer_convert.sv
module test_fb_xfer_convert;
  localparam int AW = 32;

  logic          clk, rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_idx;
  logic [31:0]   cfg_wdata;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;
  logic          wr_req;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          wr_gnt;
  logic          busy, done, fmt_err;

  int n_checks, n_fail, cyc, wcount, hold_viol;
  bit gnt_slow;
  logic [AW-1:0] log_a [512];
  logic [7:0]    log_d [512];
  logic          prev_pend;
  logic [AW-1:0] prev_a;
  logic [7:0]    prev_d;

  fb_xfer_convert i_fb_xfer_convert (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_wdata, .rd_en, .rd_addr, .rd_data,
    .wr_req, .wr_addr, .wr_data, .wr_gnt, .busy, .done, .fmt_err
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] srcword(input logic [31:0] a);
    return {~a[7:0], a[7:0] ^ 8'h3C, a[15:8] + 8'd1, a[7:0] + 8'd7};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) rd_data <= srcword(rd_addr);
    if (wr_req && wr_gnt) begin
      if (wcount < 512) begin
        log_a[wcount] <= wr_addr;
        log_d[wcount] <= wr_data;
      end
      wcount <= wcount + 1;
    end
    if (prev_pend && (!wr_req || wr_addr != prev_a || wr_data != prev_d))
      hold_viol <= hold_viol + 1;
    prev_pend <= wr_req && !wr_gnt;
    prev_a    <= wr_addr;
    prev_d    <= wr_data;
  end

  always @(negedge clk) wr_gnt <= gnt_slow ? (cyc % 3 == 2) : 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(done == 1'b1, req, "done seen", 32'(done), 1);
    check(busy == 1'b0, "R9", "busy low at done", 32'(busy), 0);
  endtask

  task automatic setup(input logic [31:0] ia, input logic [31:0] oa,
                       input int iw, input int ow, input int oh, input logic [31:0] fl);
    cfg_write(3'd0, ia);
    cfg_write(3'd1, oa);
    cfg_write(3'd2, {16'(oh), 16'(ow)});
    cfg_write(3'd3, {16'd4, 16'(iw)});
    cfg_write(3'd4, fl);
    wcount = 0;
  endtask

  task automatic check_log(input logic [31:0] ia, input logic [31:0] oa,
                           input int iw, input int ow, input int oh);
    logic [31:0] bin, bout, s, d, w;
    int n = 0;
    bit ok;
    bin  = ia << 3;   // R11 truncation of top bits
    bout = oa << 3;
    check(wcount == 3 * (ow / 2) * oh, "R4", "byte count", 32'(wcount), 32'(3 * (ow / 2) * oh));
    for (int y = 0; y < oh; y++) begin
      for (int x = 0; x < ow / 2; x++) begin
        s = bin + 32'(x * 4 + y * (iw * 4 / 2));
        d = bout + 32'(x * 3 + y * (ow * 3 / 2));
        w = srcword(s);
        for (int k = 0; k < 3; k++) begin
          if (n < wcount) begin
            ok = (log_a[n] == d + 32'(k));
            check(ok, "R6", "dest address (R5 R11)", log_a[n], d + 32'(k));
            check(log_d[n] == w[8*k +: 8], "R7", "dest byte (R5)", 32'(log_d[n]), 32'(w[8*k +: 8]));
          end
          n++;
        end
      end
    end
  endtask

  initial begin
    n_checks = 0; n_fail = 0; cyc = 0; wcount = 0; hold_viol = 0;
    gnt_slow = 1'b0; prev_pend = 1'b0; prev_a = '0; prev_d = '0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0; rd_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !fmt_err, "R1", "status after reset", {busy, done, fmt_err}, 0);
    check(!wr_req && !rd_en, "R1", "requests after reset", {wr_req, rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: start word without bit 0
    setup(32'h10, 32'h20, 4, 4, 2, 32'h0000_1000);
    cfg_write(3'd6, 32'h0000_0002);
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R2", "no start on bit0 clear", 32'(busy), 0);
    check(wcount == 0, "R2", "no writes on bit0 clear", 32'(wcount), 0);

    // main sweep
    for (int g = 0; g < 2; g++) begin
      gnt_slow = (g == 1);
      for (int a = 0; a < 2; a++) begin
        for (int b = 0; b < 3; b++) begin
          for (int c = 0; c < 2; c++) begin
            int iw = (a == 0) ? 2 : 6;
            int ow = (b == 0) ? 1 : (b == 1) ? 2 : 5;
            int oh = (c == 0) ? 1 : 3;
            logic [31:0] ia = 32'h0000_0100 + 32'(16 * (a + 2 * b + 6 * c));
            logic [31:0] oa = 32'h2000_0040 + 32'(b + 3 * g);
            setup(ia, oa, iw, ow, oh, 32'h0001_1001);
            cfg_write(3'd6, 32'h1);
            wait_done((ow / 2 == 0) ? "R9" : "R4");
            check(fmt_err == 1'b0, "R8", "no error on good pair", 32'(fmt_err), 0);
            check_log(ia, oa, iw, ow, oh);
          end
        end
      end
    end
    gnt_slow = 1'b0;

    // R9: zero height
    setup(32'h40, 32'h80, 4, 4, 0, 32'h0000_1000);
    cfg_write(3'd6, 32'h1);
    wait_done("R9");
    check(wcount == 0, "R9", "zero size writes nothing", 32'(wcount), 0);

    // R8: bad input format, then bad output format, then recovery
    setup(32'h40, 32'h80, 4, 4, 2, 32'h0000_1100);
    cfg_write(3'd6, 32'h1);
    wait_done("R8");
    check(fmt_err == 1'b1, "R8", "error on input format 1", 32'(fmt_err), 1);
    check(wcount == 0, "R8", "no writes on bad input format", 32'(wcount), 0);
    setup(32'h40, 32'h80, 4, 4, 2, 32'h0000_0000);
    cfg_write(3'd6, 32'h1);
    wait_done("R8");
    check(fmt_err == 1'b1, "R8", "error on output format 0", 32'(fmt_err), 1);
    check(wcount == 0, "R8", "no writes on bad output format", 32'(wcount), 0);
    setup(32'h40, 32'h80, 4, 4, 2, 32'h0000_1000);
    cfg_write(3'd6, 32'h1);
    wait_done("R8");
    check(fmt_err == 1'b0, "R8", "error cleared by new start", 32'(fmt_err), 0);
    check_log(32'h40, 32'h80, 4, 4, 2);

    // R3: start while busy
    gnt_slow = 1'b1;
    setup(32'h200, 32'h300, 8, 8, 4, 32'h0000_1000);
    cfg_write(3'd6, 32'h1);
    repeat (5) @(negedge clk);
    cfg_write(3'd2, {16'd1, 16'd2});
    cfg_write(3'd6, 32'h1);
    wait_done("R3");
    check_log(32'h200, 32'h300, 8, 8, 4);
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R3", "no second transfer", 32'(busy), 0);
    check(wcount == 48, "R3", "byte count unchanged", 32'(wcount), 48);
    gnt_slow = 1'b0;

    check(hold_viol == 0, "R10", "request held until grant", 32'(hold_viol), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule